// File: doc/BRIEF.md
# Arbitrary-Ratio Stream Width Converter

This block moves a bit stream from a valid/ready port of one word width to a valid/ready port of another width. Bits are only transported, never interpreted. Words that arrive first fill the least significant end of any wider word, and wider words are cut into narrower ones starting from the least significant slice. The concatenated output bits are therefore the concatenated input bits, in the same order and with the same total count.

The converter is built at elaboration time from one of three variants. If the output width is a whole multiple of the input width, a single packer is used. If the input width is a whole multiple of the output width, or the two are equal, a single slicer is used. If neither width divides the other, a packer widens the input to the least common multiple of the two widths. Its registered output word then feeds a slicer that produces the output width. Because the packer's output register sits between the two stages, both stages can work in the same cycle.

A frame holds a fixed number of input words, set by a parameter. A runtime repetition count says how many frames are accepted after reset. Once that many frames have been taken in, the input port stops accepting words, and the data already inside drains out.

Top module: `dwc_stream_conv`

## Requirements
- R1: The output bits, taken in order with each word's bit 0 first, equal the accepted input bits taken the same way. Once every word has drained, the total number of output bits equals the total number of input bits.
- R2: With a 6-bit input, a 4-bit output and 8 input words per frame, each frame passes through 4 words of 12 bits and leaves as 12 output words with the R1 bit order.
- R3: With a 4-bit input, a 6-bit output and 12 input words per frame, each frame leaves as 8 output words with the R1 bit order.
- R4: When the output width is an integer multiple of the input width (2 to 8 bits), each output word holds the next four input words, and the first of them sits in bits 1:0.
- R5: When the input width is an integer multiple of the output width (8 to 2 bits), each input word leaves as four output words, starting with bits 1:0.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value in the next cycle.
- R7: After reps times FRAME_WORDS input words have been accepted, in_ready stays low, and no further input word is accepted until reset.
- R8: In the first cycle after rst is released, out_valid is low.
- R9: A parameter set is rejected at elaboration when FRAME_WORDS times IN_W is not a multiple of the least common multiple of IN_W and OUT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reps | input | REP_W | Number of frames to accept after reset; held stable |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Converter accepts the input word |
| in_data | input | IN_W | Input word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | OUT_W | Output word |

## Verification
The bench builds four instances side by side, one per variant. The 6-to-4 and 4-to-6 instances exercise the two-stage path through a 12-bit intermediate word. The 2-to-8 instance exercises the direct packer, and the 8-to-2 instance exercises the direct slicer. Each instance runs three frames while the valid and ready signals toggle at random. This causes stalls on both sides, with backpressure arriving in the middle of a slice sequence, and it lets the bench check the frame limit and the full drain of every bit.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  function automatic int gcd_f(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm_f(input int a, input int b);
    return (a / gcd_f(a, b)) * b;
  endfunction

  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dwc_pack.sv
module dwc_pack #(
  parameter int NW = 2,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [NW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [WW-1:0] m_data
);
  localparam int RATIO = WW / NW;
  localparam int CW    = dwc_pkg::cnt_w(RATIO);
  localparam int AW    = (RATIO - 1) * NW;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] acc_q;
  logic [WW-1:0] word_q;
  logic          vld_q;
  logic          take;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign s_ready = !at_last || !vld_q || m_ready;
  assign take    = s_valid && s_ready;
  assign m_valid = vld_q;
  assign m_data  = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (take && at_last) begin
        vld_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        if (m_ready) vld_q <= 1'b0;
        if (take) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      if (at_last) begin
        word_q <= {s_data, acc_q};
      end else begin
        for (int i = 0; i < RATIO - 1; i++) begin
          if (cnt_q == CW'(i)) acc_q[i*NW +: NW] <= s_data;
        end
      end
    end
  end

endmodule

// File: rtl/dwc_slice.sv
module dwc_slice #(
  parameter int WW = 8,
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [WW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [NW-1:0] m_data
);
  localparam int RATIO = WW / NW;
  localparam int CW    = dwc_pkg::cnt_w(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] idx_q;
  logic [WW-1:0] word_q;
  logic          vld_q;
  logic          take;
  logic          emit;

  assign emit    = vld_q && m_ready;
  assign s_ready = !vld_q || (m_ready && idx_q == LAST);
  assign take    = s_valid && s_ready;
  assign m_valid = vld_q;

  always_comb begin
    m_data = word_q[NW-1:0];
    for (int i = 1; i < RATIO; i++) begin
      if (idx_q == CW'(i)) m_data = word_q[i*NW +: NW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      idx_q <= '0;
    end else if (emit) begin
      if (idx_q == LAST) vld_q <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) word_q <= s_data;
  end

endmodule

// File: rtl/dwc_frame_gate.sv
module dwc_frame_gate #(
  parameter int FRAME_WORDS = 8,
  parameter int REP_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REP_W-1:0] reps,
  input  logic             fire,
  output logic             open
);
  localparam int WCW = dwc_pkg::cnt_w(FRAME_WORDS);
  localparam logic [WCW-1:0] WLAST = WCW'(FRAME_WORDS - 1);

  logic [WCW-1:0]   word_q;
  logic [REP_W-1:0] frame_q;

  assign open = (frame_q < reps);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      frame_q <= '0;
    end else if (fire) begin
      if (word_q == WLAST) begin
        word_q  <= '0;
        frame_q <= frame_q + 1'b1;
      end else begin
        word_q <= word_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dwc_stream_conv.sv
module dwc_stream_conv #(
  parameter int IN_W        = 6,
  parameter int OUT_W       = 4,
  parameter int FRAME_WORDS = 8,
  parameter int REP_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REP_W-1:0] reps,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int MID_W = dwc_pkg::lcm_f(IN_W, OUT_W);

  // R9: frame must fill a whole number of intermediate words
  if ((FRAME_WORDS * IN_W) % MID_W != 0) begin : g_bad_frame
    $error("frame bit count is not a multiple of the common width");
  end

  logic core_valid;
  logic core_ready;
  logic gate_open;

  assign core_valid = in_valid && gate_open;
  assign in_ready   = core_ready && gate_open;

  dwc_frame_gate #(.FRAME_WORDS(FRAME_WORDS), .REP_W(REP_W)) gate_i (
    .clk(clk), .rst(rst), .reps(reps),
    .fire(in_valid && in_ready), .open(gate_open)
  );

  if (IN_W % OUT_W == 0) begin : g_slice
    dwc_slice #(.WW(IN_W), .NW(OUT_W)) slc_i (
      .clk(clk), .rst(rst),
      .s_valid(core_valid), .s_ready(core_ready), .s_data(in_data),
      .m_valid(out_valid), .m_ready(out_ready), .m_data(out_data)
    );
  end else if (OUT_W % IN_W == 0) begin : g_pack
    dwc_pack #(.NW(IN_W), .WW(OUT_W)) pck_i (
      .clk(clk), .rst(rst),
      .s_valid(core_valid), .s_ready(core_ready), .s_data(in_data),
      .m_valid(out_valid), .m_ready(out_ready), .m_data(out_data)
    );
  end else begin : g_two_stage
    logic             mid_valid;
    logic             mid_ready;
    logic [MID_W-1:0] mid_data;

    dwc_pack #(.NW(IN_W), .WW(MID_W)) pck_i (
      .clk(clk), .rst(rst),
      .s_valid(core_valid), .s_ready(core_ready), .s_data(in_data),
      .m_valid(mid_valid), .m_ready(mid_ready), .m_data(mid_data)
    );
    dwc_slice #(.WW(MID_W), .NW(OUT_W)) slc_i (
      .clk(clk), .rst(rst),
      .s_valid(mid_valid), .s_ready(mid_ready), .s_data(mid_data),
      .m_valid(out_valid), .m_ready(out_ready), .m_data(out_data)
    );
  end

endmodule

// File: rtl/dwc_stream_conv_chk.sv
module dwc_stream_conv_chk #(
  parameter int IN_W        = 6,
  parameter int OUT_W       = 4,
  parameter int FRAME_WORDS = 8,
  parameter int REP_W       = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [REP_W-1:0] reps,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  logic [47:0] in_words_q;
  logic [47:0] in_bits_q;
  logic [47:0] out_bits_q;
  logic [47:0] limit;

  assign limit = 48'(reps) * 48'(FRAME_WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_words_q <= '0;
      in_bits_q  <= '0;
      out_bits_q <= '0;
    end else begin
      if (in_valid && in_ready) begin
        in_words_q <= in_words_q + 48'd1;
        in_bits_q  <= in_bits_q + 48'(IN_W);
      end
      if (out_valid && out_ready) out_bits_q <= out_bits_q + 48'(OUT_W);
    end
  end

  a_r7_rep_limit: assert property (@(posedge clk) disable iff (rst)
    (in_words_q >= limit) |-> !in_ready);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r1_no_excess: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> (out_bits_q + 48'(OUT_W) <= in_bits_q));

  a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

endmodule

bind dwc_stream_conv dwc_stream_conv_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .FRAME_WORDS(FRAME_WORDS), .REP_W(REP_W)
) chk_i (.*);

// File: tb/dwc_lane_tb.sv
module dwc_lane_tb #(
  parameter int    IN_W  = 6,
  parameter int    OUT_W = 4,
  parameter int    FRAME = 8,
  parameter int    REPS  = 3,
  parameter int    SEED  = 1,
  parameter string TAG   = "R2"
) (
  input  logic clk,
  input  logic rst,
  output int   checks,
  output int   fails,
  output logic done
);
  logic             in_valid, in_ready, out_valid, out_ready;
  logic [IN_W-1:0]  in_data;
  logic [OUT_W-1:0] out_data;
  logic [15:0]      reps;

  dwc_stream_conv #(.IN_W(IN_W), .OUT_W(OUT_W), .FRAME_WORDS(FRAME), .REP_W(16)) dut_i (
    .clk(clk), .rst(rst), .reps(reps),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  bit q[$];

  function automatic logic [OUT_W-1:0] pop_word();
    logic [OUT_W-1:0] w;
    w = '0;
    for (int i = 0; i < OUT_W; i++) begin
      if (q.size() > 0) w[i] = q.pop_front();
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s lane %0d->%0d: actual=%0h expected=%0h", req, IN_W, OUT_W, act, exp);
    end
  endtask

  initial begin
    int sent;
    bit stalled;
    logic [OUT_W-1:0] held;
    logic [OUT_W-1:0] exp_w;
    void'($urandom(SEED));
    checks = 0; fails = 0; done = 0;
    in_valid = 0; out_ready = 0; in_data = '0; reps = 16'(REPS);
    sent = 0; stalled = 0; held = '0;
    @(negedge clk);
    while (rst) @(negedge clk);
    check(out_valid == 1'b0, "R8", out_valid, 0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (stalled) check(out_valid && out_data == held, "R6", out_data, held);
      if (sent == REPS * FRAME && q.size() == 0) break;
      in_valid  = ($urandom % 10) < 7;
      in_data   = IN_W'($urandom);
      out_ready = (cyc < 40) ? (($urandom % 10) < 2) : (($urandom % 10) < 6);
      #1;
      if (in_valid && in_ready) begin
        for (int i = 0; i < IN_W; i++) q.push_back(in_data[i]);
        sent++;
      end
      if (out_valid && out_ready) begin
        exp_w = pop_word();
        check(out_data == exp_w, TAG, out_data, exp_w);
      end
      stalled = out_valid && !out_ready;
      held = out_data;
    end
    in_valid = 1; out_ready = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R7", in_ready, 0);
    end
    check(sent == REPS * FRAME, "R7", sent, REPS * FRAME);
    check(q.size() == 0 && out_valid == 1'b0, "R1", q.size(), 0);
    in_valid = 0;
    done = 1;
  end

endmodule

// File: tb/dwc_stream_conv_tb_top.sv
`timescale 1ns/1ps
module dwc_stream_conv_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int   c0, c1, c2, c3, f0, f1, f2, f3;
  logic d0, d1, d2, d3;

  // R2: 6 -> 12 -> 4 ; R3: 4 -> 12 -> 6 ; R4: 2 -> 8 ; R5: 8 -> 2
  dwc_lane_tb #(.IN_W(6), .OUT_W(4), .FRAME(8),  .REPS(3), .SEED(11), .TAG("R2")) dut_i (
    .clk(clk), .rst(rst), .checks(c0), .fails(f0), .done(d0));
  dwc_lane_tb #(.IN_W(4), .OUT_W(6), .FRAME(12), .REPS(3), .SEED(22), .TAG("R3")) lane_up_odd (
    .clk(clk), .rst(rst), .checks(c1), .fails(f1), .done(d1));
  dwc_lane_tb #(.IN_W(2), .OUT_W(8), .FRAME(4),  .REPS(3), .SEED(33), .TAG("R4")) lane_pack (
    .clk(clk), .rst(rst), .checks(c2), .fails(f2), .done(d2));
  dwc_lane_tb #(.IN_W(8), .OUT_W(2), .FRAME(2),  .REPS(3), .SEED(44), .TAG("R5")) lane_slice (
    .clk(clk), .rst(rst), .checks(c3), .fails(f3), .done(d3));

  initial begin
    int wd_fail;
    wd_fail = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (d0 && d1 && d2 && d3) break;
    end
    if (!(d0 && d1 && d2 && d3)) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual=running expected=done");
    end
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", c0 + c1 + c2 + c3 + wd_fail,
             f0 + f1 + f2 + f3 + wd_fail);
    $finish;
  end

endmodule